// File: doc/BRIEF.md
# PHY Control Register Bank with Bit-Masked Writes

This block is a small bank of 32-bit control registers for a PCIe PHY, written and read over a plain register bus. Every written word carries its own per-bit enable mask in its upper half-word. Software can therefore change one field without reading the register first, and bits whose enable is clear keep their value.

One register drives a PHY test/configuration port with a 6-bit address, 4-bit data and a strobe bit. When the stored strobe bit goes from 0 to 1, the block sends a configuration write to the PHY side. That write is a one-clock pulse and carries the address and data stored at that moment. A second register holds one transmit electrical-idle-off control for each lane. A read-only register reports the PHY PLL lock and PLL output indications.

Word index map: 0 is test-port control, 1 is lane control, 2 is status, and 3 is unused.

Top module: `phy_ctl_top`

## Requirements
- R1: While `rst_ni` is low, every stored bit clears to zero. After reset, every readable register returns zero and `cfg_wr_o`, `cfg_addr_o`, `cfg_data_o` and `tx_idle_off_o` are zero.
- R2: A write (`bus_we_i` high at a clock edge) updates stored bit k (0..15) only when `bus_wdata_i[16+k]` is 1. A write whose bits 31:16 are all zero leaves the register unchanged.
- R3: `bus_rdata_o` returns the stored low half-word of the register that `bus_addr_i` selects, in the same cycle. Bits 31:16 always read zero, unimplemented bits read zero, and word index 3 reads zero.
- R4: In the test-port control register (index 0), bit 0 is the strobe, bits 6:1 are the configuration address and bits 10:7 are the configuration data. Bits 15:11 are not implemented.
- R5: When the stored strobe goes from 0 to 1, `cfg_wr_o` is high for exactly one clock, starting at the edge after the write. In that same cycle, `cfg_addr_o` and `cfg_data_o` show the address and data stored when the strobe rose.
- R6: No configuration pulse occurs while the strobe stays 1, when it falls, or when the address or data change with the strobe high.
- R7: Lane control (index 1) bit 3+n drives `tx_idle_off_o[n]` for lane n (at most 4 lanes), with its enable at bit 19+n. All other bits of index 1 are not implemented.
- R8: Status (index 2) reads PLL locked in bit 9 and PLL output active in bit 10. Each bit shows the input as sampled at the previous clock edge, and writes to index 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write enable for the word at `bus_addr_i` |
| bus_addr_i | input | 2 | Word index |
| bus_wdata_i | input | 32 | Write data: bits 31:16 are enables for bits 15:0 |
| bus_rdata_o | output | 32 | Read data of the selected word |
| pll_locked_i | input | 1 | PHY PLL locked indication |
| pll_out_i | input | 1 | PHY PLL output active indication |
| cfg_wr_o | output | 1 | One-clock configuration write pulse |
| cfg_addr_o | output | 6 | Configuration address for the pulse |
| cfg_data_o | output | 4 | Configuration data for the pulse |
| tx_idle_off_o | output | LANES | Per-lane transmit electrical-idle-off control |

## Verification
The results fall due at different times after a stimulus:
- Register contents and the lane outputs change at the write edge itself, and reads are combinational, so those checks sample at the falling edge right after the write.
- The configuration pulse comes one edge later. It is checked low at that first falling edge, high with its payload at the next, and low again at the one after.
- A status read reflects a PLL input one edge after the input changes. The bench moves the inputs at a falling edge and samples after the following rising edge.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned IDX_W  = 2;

  // test-port control fields
  localparam int unsigned STRB_BIT  = 0;
  localparam int unsigned TADDR_LSB = 1;
  localparam int unsigned TADDR_W   = 6;
  localparam int unsigned TDATA_LSB = TADDR_LSB + TADDR_W;
  localparam int unsigned TDATA_W   = 4;
  localparam int unsigned TEST_TOP  = TDATA_LSB + TDATA_W;

  // lane control and status fields
  localparam int unsigned LANE_LSB  = 3;
  localparam int unsigned MAX_LANES = 4;
  localparam int unsigned LOCK_BIT  = 9;
  localparam int unsigned POUT_BIT  = 10;

  typedef enum logic [IDX_W-1:0] {
    IDX_TEST   = 2'd0,
    IDX_LANE   = 2'd1,
    IDX_STATUS = 2'd2,
    IDX_NONE   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/phy_ctl_mreg.sv
module phy_ctl_mreg
  import phy_ctl_pkg::*;
#(
  parameter logic [HALF_W-1:0] IMPL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [HALF_W-1:0] q_o
);
  logic [HALF_W-1:0] en, d, q;

  assign en = wdata_i[WORD_W-1:HALF_W];
  assign d  = wdata_i[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= ((q & ~en) | (d & en)) & IMPL;
  end

  assign q_o = q;
endmodule

// File: rtl/phy_ctl_pulse.sv
module phy_ctl_pulse
  import phy_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strb_i,
  input  logic [TADDR_W-1:0] addr_i,
  input  logic [TDATA_W-1:0] data_i,
  output logic               wr_o,
  output logic [TADDR_W-1:0] addr_o,
  output logic [TDATA_W-1:0] data_o
);
  logic               strb_prev, wr_q;
  logic [TADDR_W-1:0] addr_q;
  logic [TDATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_prev <= 1'b0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      strb_prev <= strb_i;
      wr_q      <= strb_i & ~strb_prev;
      if (strb_i && !strb_prev) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign wr_o   = wr_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/phy_ctl_status.sv
module phy_ctl_status #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/phy_ctl_top.sv
module phy_ctl_top
  import phy_ctl_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [IDX_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  input  logic               pll_locked_i,
  input  logic               pll_out_i,
  output logic               cfg_wr_o,
  output logic [TADDR_W-1:0] cfg_addr_o,
  output logic [TDATA_W-1:0] cfg_data_o,
  output logic [LANES-1:0]   tx_idle_off_o
);
  localparam logic [HALF_W-1:0] TEST_IMPL = HALF_W'((1 << TEST_TOP) - 1);
  localparam logic [HALF_W-1:0] LANE_IMPL = HALF_W'(((1 << LANES) - 1) << LANE_LSB);

  initial begin
    if (LANES < 1 || LANES > MAX_LANES) $error("LANES out of range");
  end

  logic [HALF_W-1:0] test_q, lane_q;
  logic [1:0]        sts_q;
  logic              wr_test, wr_lane;

  assign wr_test = bus_we_i && (bus_addr_i == IDX_TEST);
  assign wr_lane = bus_we_i && (bus_addr_i == IDX_LANE);

  phy_ctl_mreg #(.IMPL(TEST_IMPL)) u_test (
    .clk_i, .rst_ni, .wr_i(wr_test), .wdata_i(bus_wdata_i), .q_o(test_q)
  );

  phy_ctl_mreg #(.IMPL(LANE_IMPL)) u_lane (
    .clk_i, .rst_ni, .wr_i(wr_lane), .wdata_i(bus_wdata_i), .q_o(lane_q)
  );

  phy_ctl_pulse u_pulse (
    .clk_i, .rst_ni,
    .strb_i (test_q[STRB_BIT]),
    .addr_i (test_q[TADDR_LSB +: TADDR_W]),
    .data_i (test_q[TDATA_LSB +: TDATA_W]),
    .wr_o   (cfg_wr_o),
    .addr_o (cfg_addr_o),
    .data_o (cfg_data_o)
  );

  phy_ctl_status #(.W(2)) u_sts (
    .clk_i, .rst_ni, .d_i({pll_out_i, pll_locked_i}), .q_o(sts_q)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign tx_idle_off_o[n] = lane_q[LANE_LSB + n];
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      IDX_TEST: bus_rdata_o[HALF_W-1:0] = test_q;
      IDX_LANE: bus_rdata_o[HALF_W-1:0] = lane_q;
      IDX_STATUS: begin
        bus_rdata_o[LOCK_BIT] = sts_q[0];
        bus_rdata_o[POUT_BIT] = sts_q[1];
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/phy_ctl_chk.sv
module phy_ctl_chk
  import phy_ctl_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [IDX_W-1:0]   bus_addr_i,
  input logic [WORD_W-1:0]  bus_wdata_i,
  input logic [WORD_W-1:0]  bus_rdata_o,
  input logic               pll_locked_i,
  input logic               cfg_wr_o,
  input logic [TADDR_W-1:0] cfg_addr_o,
  input logic [TDATA_W-1:0] cfg_data_o,
  input logic [LANES-1:0]   tx_idle_off_o,
  input logic               strb_i,
  input logic [TADDR_W-1:0] taddr_i,
  input logic [TDATA_W-1:0] tdata_i
);
  logic strb_prev, past_ok, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_prev <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      strb_prev <= strb_i;
      past_ok   <= 1'b1;
    end
  end

  assign rise = strb_i && !strb_prev;

  a_r5_rise_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> cfg_wr_o);
  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);
  a_r5_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (cfg_addr_o == $past(taddr_i) && cfg_data_o == $past(tdata_i)));
  a_r6_no_rise_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> !cfg_wr_o);
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[WORD_W-1:HALF_W] == '0);
  a_r8_lock_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && bus_addr_i == IDX_STATUS) |-> bus_rdata_o[LOCK_BIT] == $past(pll_locked_i));

  for (genvar n = 0; n < LANES; n++) begin : g_lane_chk
    a_r7_lane_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == IDX_LANE && !bus_wdata_i[HALF_W + LANE_LSB + n])
        |=> $stable(tx_idle_off_o[n]));
  end
endmodule

bind phy_ctl_top phy_ctl_chk #(.LANES(LANES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .pll_locked_i  (pll_locked_i),
  .cfg_wr_o      (cfg_wr_o),
  .cfg_addr_o    (cfg_addr_o),
  .cfg_data_o    (cfg_data_o),
  .tx_idle_off_o (tx_idle_off_o),
  .strb_i        (test_q[0]),
  .taddr_i       (test_q[6:1]),
  .tdata_i       (test_q[10:7])
);

// File: tb/phy_ctl_top_tb.sv
module phy_ctl_top_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LANES = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lock = 1'b0, pout = 1'b0;
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_data;
  logic [LANES-1:0] tx_off;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctl_top #(.LANES(LANES)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pll_locked_i(lock),
    .pll_out_i(pout), .cfg_wr_o(cfg_wr), .cfg_addr_o(cfg_addr),
    .cfg_data_o(cfg_data), .tx_idle_off_o(tx_off)
  );

  // {index, write word, expected readback of that index}
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'hFFFF_FFFE, 32'h0000_07FE},  // R2 R3 R4 full write, bits 15:11 unimplemented
    {2'd0, 32'h0000_0000, 32'h0000_07FE},  // R2 empty mask
    {2'd0, 32'h0780_0000, 32'h0000_007E},  // R2 clear data field 10:7
    {2'd0, 32'h007E_0014, 32'h0000_0014},  // R4 address field 6:1 = 0x0A
    {2'd1, 32'hFFFF_FFFF, 32'h0000_0078},  // R7 lane bits 6:3
    {2'd1, 32'h0010_0000, 32'h0000_0068},  // R7 clear lane 1 only
    {2'd2, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 status ignores writes
    {2'd3, 32'hFFFF_FFFF, 32'h0000_0000}   // R3 unused index
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      addr = 2'(i); #1;
      chk("R1 read after reset", rdata, 32'h0);
    end
    chk("R1 outputs after reset", {21'h0, cfg_wr, cfg_addr, cfg_data}, 32'h0);
    chk("R1 lanes after reset", 32'(tx_off), 32'h0);

    for (int i = 0; i < 8; i++) begin
      bus_wr(VEC[i][65:64], VEC[i][63:32]);
      chk($sformatf("R2/R3 vector %0d", i), rdata, VEC[i][31:0]);
      chk($sformatf("R6 no pulse vector %0d", i), 32'(cfg_wr), 32'h0);
    end
    chk("R7 lane outputs", 32'(tx_off), 32'hD);

    // R5 pulse: addr 0x2A, data 0x9, strobe rises
    bus_wr(2'd0, 32'h07FF_04D5);
    chk("R5 not before next edge", 32'(cfg_wr), 32'h0);
    @(negedge clk);
    chk("R5 pulse high", 32'(cfg_wr), 32'h1);
    chk("R5 pulse address", 32'(cfg_addr), 32'h2A);
    chk("R5 pulse data", 32'(cfg_data), 32'h9);
    @(negedge clk);
    chk("R5 pulse one clock", 32'(cfg_wr), 32'h0);

    // R6 strobe held high, rewritten, fields changed
    bus_wr(2'd0, 32'h0001_0001);
    @(negedge clk);
    chk("R6 strobe rewrite high", 32'(cfg_wr), 32'h0);
    bus_wr(2'd0, 32'h007E_0006);
    @(negedge clk);
    chk("R6 address change strobe high", 32'(cfg_wr), 32'h0);
    chk("R6 held payload", 32'(cfg_addr), 32'h2A);
    bus_wr(2'd0, 32'h0001_0000);
    @(negedge clk);
    chk("R6 strobe fall", 32'(cfg_wr), 32'h0);
    bus_wr(2'd0, 32'h0001_0001);
    @(negedge clk);
    chk("R5 second rise pulse", 32'(cfg_wr), 32'h1);
    chk("R5 second rise address", 32'(cfg_addr), 32'h03);

    // R8 status timing
    addr = 2'd2;
    @(negedge clk);
    lock = 1'b1; #1;
    chk("R8 not before edge", rdata, 32'h0);
    @(negedge clk);
    chk("R8 lock bit 9", rdata, 32'h0000_0200);
    pout = 1'b1;
    @(negedge clk);
    chk("R8 output bit 10", rdata, 32'h0000_0600);
    lock = 1'b0;
    @(negedge clk);
    chk("R8 lock drop", rdata, 32'h0000_0400);

    // R1 mid-run reset
    @(negedge clk);
    rst_ni = 1'b0; lock = 1'b0; pout = 1'b0; #1;
    addr = 2'd0; #1;
    chk("R1 test reg cleared", rdata, 32'h0);
    addr = 2'd1; #1;
    chk("R1 lane reg cleared", rdata, 32'h0);
    chk("R1 lane outputs cleared", 32'(tx_off), 32'h0);
    chk("R1 cfg outputs cleared", {21'h0, cfg_wr, cfg_addr, cfg_data}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule